// File: doc/BRIEF.md
# GPIO Controller with Interrupts

This block is a sixteen-pin general-purpose I/O peripheral that sits behind a simple memory-mapped register bus with byte addresses and 16-bit data. Software chooses the direction of every pin. It changes output levels through separate write-one-to-set and write-one-to-clear registers, so no read-modify-write sequence is needed. Pin levels are brought into the clock domain through a two-flop synchroniser and can be read back.

Every pin can raise an interrupt in one of these modes: high level, low level, rising edge, falling edge, or either edge. Raw events are stored in a sticky status vector. Each pin has a mask bit and an enable bit, and the two together gate that status into a pending view. Software acknowledges pending pins by writing ones to an acknowledge register. A single registered interrupt line is high while any pending bit is set. Accesses are single-cycle: a write takes effect at the clock edge where `busSel` and `busWrite` are both high, and read data is a combinational function of `busAddr`.

Register offsets, which software decodes: 0x00 direction, 0x04 trigger-type select, 0x08 level polarity, 0x0C rise enable, 0x10 fall enable, 0x14 synchronised input (read-only), 0x18 output set, 0x1C output clear, 0x20 output value, 0x28 mask, 0x2C enable, 0x30 pending (read-only), 0x34 acknowledge. The write-only registers read as zero.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, direction, output value, trigger-type select, polarity, both edge enables and enable all read 0. Mask reads 0xFFFF, pending reads 0 and `irqOut` is 0.
- R2: A pin whose direction bit (0x00) is 1 is an output and a pin whose bit is 0 is an input. `pinOutEn` equals the direction register, and the register reads back what was written.
- R3: Writing a word to 0x18 sets every output-value bit that is 1 in the word and leaves the other bits unchanged. `pinOut` shows the output value.
- R4: Writing a word to 0x1C clears every output-value bit that is 1 in the word and leaves the other bits unchanged. The output value at 0x20 can also be written and read directly.
- R5: Reading 0x14 returns the pin levels after two rising clock edges of synchronisation. After only one edge it still returns the previous level.
- R6: When a pin's trigger-type bit (0x04) is 1, the pin is level-triggered. A polarity bit (0x08) of 1 means active high and 0 means active low. The status bit is re-latched on every cycle the level is active, so an acknowledge has no lasting effect while the level holds.
- R7: When a pin's trigger-type bit is 0, the pin is edge-triggered. A rise-enable bit (0x0C) latches rising edges, a fall-enable bit (0x10) latches falling edges, and both together latch either edge. Edges are detected on the synchronised input and stay latched until acknowledged.
- R8: A pending bit (0x30) is set only when the latched status bit is set, the mask bit (0x28) is 0 and the enable bit (0x2C) is 1. The latched status is kept while the pin is masked.
- R9: Writing ones to 0x34 clears the matching latched status bits. If a new event arrives in the same cycle as its acknowledge, the bit stays set.
- R10: `irqOut` is registered. It is high one cycle after any pending bit is set and low one cycle after all pending bits are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (combinational) |
| pinIn | input | 16 | Asynchronous pin levels |
| pinOut | output | 16 | Output value driven to the pads |
| pinOutEn | output | 16 | Per-pin output enable |
| irqOut | output | 1 | Combined interrupt |

## Verification
The assertions assume that at most one register access is decoded per cycle. They also assume that an event seen on a pin comes only from the synchronised copy, never from the raw pin. The bench drives the bus and the pins only on falling clock edges and performs one access at a time. It places the acknowledge exactly on the cycle in which a synchronised edge is latched, to test the race between a new event and its acknowledge. The full sweep covers every pin in every trigger mode, with all other pins masked out, so each pending word has one expected bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] OFS_DIR  = 8'h00;
  localparam logic [7:0] OFS_TYPE = 8'h04;
  localparam logic [7:0] OFS_POL  = 8'h08;
  localparam logic [7:0] OFS_RISE = 8'h0C;
  localparam logic [7:0] OFS_FALL = 8'h10;
  localparam logic [7:0] OFS_IN   = 8'h14;
  localparam logic [7:0] OFS_SET  = 8'h18;
  localparam logic [7:0] OFS_CLR  = 8'h1C;
  localparam logic [7:0] OFS_OUT  = 8'h20;
  localparam logic [7:0] OFS_MASK = 8'h28;
  localparam logic [7:0] OFS_EN   = 8'h2C;
  localparam logic [7:0] OFS_PEND = 8'h30;
  localparam logic [7:0] OFS_ACK  = 8'h34;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DIR, RD_TYPE, RD_POL, RD_RISE, RD_FALL,
    RD_IN, RD_OUT, RD_MASK, RD_EN, RD_PEND
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrType;
    logic   wrPol;
    logic   wrRise;
    logic   wrFall;
    logic   setOut;
    logic   clrOut;
    logic   wrOut;
    logic   wrMask;
    logic   wrEn;
    logic   ackPend;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);
  logic wrAcc;
  assign wrAcc = busSel && busWrite;

  always_comb begin
    strb = '0;
    strb.rdSel = RD_ZERO;
    case (busAddr)
      ADDR_W'(OFS_DIR):  begin strb.wrDir  = wrAcc; strb.rdSel = RD_DIR;  end
      ADDR_W'(OFS_TYPE): begin strb.wrType = wrAcc; strb.rdSel = RD_TYPE; end
      ADDR_W'(OFS_POL):  begin strb.wrPol  = wrAcc; strb.rdSel = RD_POL;  end
      ADDR_W'(OFS_RISE): begin strb.wrRise = wrAcc; strb.rdSel = RD_RISE; end
      ADDR_W'(OFS_FALL): begin strb.wrFall = wrAcc; strb.rdSel = RD_FALL; end
      ADDR_W'(OFS_IN):   strb.rdSel = RD_IN;
      ADDR_W'(OFS_SET):  strb.setOut = wrAcc;
      ADDR_W'(OFS_CLR):  strb.clrOut = wrAcc;
      ADDR_W'(OFS_OUT):  begin strb.wrOut  = wrAcc; strb.rdSel = RD_OUT;  end
      ADDR_W'(OFS_MASK): begin strb.wrMask = wrAcc; strb.rdSel = RD_MASK; end
      ADDR_W'(OFS_EN):   begin strb.wrEn   = wrAcc; strb.rdSel = RD_EN;   end
      ADDR_W'(OFS_PEND): strb.rdSel = RD_PEND;
      ADDR_W'(OFS_ACK):  strb.ackPend = wrAcc;
      default: ;
    endcase
  end

  // one access per cycle: at most one register write strobe (R3, R4, R9)
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDir, strb.wrType, strb.wrPol, strb.wrRise, strb.wrFall,
              strb.setOut, strb.clrOut, strb.wrOut, strb.wrMask, strb.wrEn,
              strb.ackPend}));
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic [PIN_COUNT-1:0] wdata,
  output logic [PIN_COUNT-1:0] rdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic                 irqOut
);
  localparam logic [PIN_COUNT-1:0] ALL_ONES = '1;

  logic [PIN_COUNT-1:0] dirReg, typeReg, polReg, riseReg, fallReg;
  logic [PIN_COUNT-1:0] outReg, maskReg, enReg, statusReg, prevIn;
  logic [PIN_COUNT-1:0] syncChain [SYNC_STAGES];
  logic [PIN_COUNT-1:0] syncIn, levelHit, edgeHit, ackMask, pendVec;

  // input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= pinIn;
  end
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= '0;
      else       syncChain[s] <= syncChain[s-1];
    end
  end
  assign syncIn = syncChain[SYNC_STAGES-1];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0; typeReg <= '0; polReg <= '0; riseReg <= '0;
      fallReg <= '0; maskReg <= ALL_ONES; enReg <= '0;
    end else begin
      if (strb.wrDir)  dirReg  <= wdata;
      if (strb.wrType) typeReg <= wdata;
      if (strb.wrPol)  polReg  <= wdata;
      if (strb.wrRise) riseReg <= wdata;
      if (strb.wrFall) fallReg <= wdata;
      if (strb.wrMask) maskReg <= wdata;
      if (strb.wrEn)   enReg   <= wdata;
    end
  end

  // output value: direct write, atomic set and clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outReg <= '0;
    else if (strb.wrOut)  outReg <= wdata;
    else if (strb.setOut) outReg <= outReg | wdata;
    else if (strb.clrOut) outReg <= outReg & ~wdata;
  end

  // event detection and sticky status
  assign levelHit = typeReg & ~(syncIn ^ polReg);
  assign edgeHit  = ~typeReg & ((riseReg & syncIn & ~prevIn) |
                                (fallReg & ~syncIn & prevIn));
  assign ackMask  = strb.ackPend ? wdata : '0;
  assign pendVec  = statusReg & ~maskReg & enReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn    <= '0;
      statusReg <= '0;
      irqOut    <= 1'b0;
    end else begin
      prevIn    <= syncIn;
      statusReg <= (statusReg & ~ackMask) | levelHit | edgeHit;
      irqOut    <= |pendVec;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_DIR:  rdata = dirReg;
      RD_TYPE: rdata = typeReg;
      RD_POL:  rdata = polReg;
      RD_RISE: rdata = riseReg;
      RD_FALL: rdata = fallReg;
      RD_IN:   rdata = syncIn;
      RD_OUT:  rdata = outReg;
      RD_MASK: rdata = maskReg;
      RD_EN:   rdata = enReg;
      RD_PEND: rdata = pendVec;
      default: rdata = '0;
    endcase
  end

  assign pinOut   = outReg;
  assign pinOutEn = dirReg;

  assert_set_out_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOut |=> ((outReg & $past(wdata)) == $past(wdata)));
  assert_clr_out_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrOut |=> ((outReg & $past(wdata)) == '0));
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setOut || strb.clrOut || strb.wrOut) |=> $stable(outReg));
  assert_edge_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeHit) |=> ((statusReg & $past(edgeHit)) == $past(edgeHit)));
  assert_level_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|levelHit) |=> ((statusReg & $past(levelHit)) == $past(levelHit)));
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackPend && !(|(levelHit | edgeHit))) |=> ((statusReg & $past(wdata)) == '0));
  assert_irq_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusReg & ~maskReg & enReg)) |=> irqOut);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [PIN_COUNT-1:0] busWdata,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic                 irqOut
);
  ctrlStrobe_t strb;

  gpio_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .strb(strb)
  );

  gpio_irq_datapath #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .rdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );
endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0, busRdata, pinIn = '0, pinOut, pinOutEn;
  logic        irqOut;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic expectReg(input logic [7:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    doRead(a, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic runTests();
    logic [15:0] v, bitM, idle;
    // R1 reset state
    expectReg(8'h00, 16'h0000, "R1 dir");
    expectReg(8'h20, 16'h0000, "R1 out");
    expectReg(8'h04, 16'h0000, "R1 type");
    expectReg(8'h08, 16'h0000, "R1 pol");
    expectReg(8'h0C, 16'h0000, "R1 rise");
    expectReg(8'h10, 16'h0000, "R1 fall");
    expectReg(8'h28, 16'hFFFF, "R1 mask");
    expectReg(8'h2C, 16'h0000, "R1 enable");
    expectReg(8'h30, 16'h0000, "R1 pending");
    check(irqOut === 1'b0, "R1 irq", {15'd0, irqOut}, 16'h0);

    // R2 direction
    doWrite(8'h00, 16'hA5C3);
    expectReg(8'h00, 16'hA5C3, "R2 dir readback");
    check(pinOutEn === 16'hA5C3, "R2 pinOutEn", pinOutEn, 16'hA5C3);

    // R3 / R4 output value
    doWrite(8'h18, 16'h00F0);
    check(pinOut === 16'h00F0, "R3 set", pinOut, 16'h00F0);
    doWrite(8'h18, 16'h0F00);
    check(pinOut === 16'h0FF0, "R3 set keeps others", pinOut, 16'h0FF0);
    doWrite(8'h18, 16'h0000);
    check(pinOut === 16'h0FF0, "R3 zero set no effect", pinOut, 16'h0FF0);
    doWrite(8'h1C, 16'h00A0);
    check(pinOut === 16'h0F50, "R4 clear", pinOut, 16'h0F50);
    doWrite(8'h1C, 16'h0000);
    check(pinOut === 16'h0F50, "R4 zero clear no effect", pinOut, 16'h0F50);
    doWrite(8'h20, 16'h1234);
    expectReg(8'h20, 16'h1234, "R4 direct write");
    expectReg(8'h18, 16'h0000, "R4 set reads zero");

    // R5 synchronised input
    for (int k = 1; k < 9; k++) begin
      logic [15:0] oldP, newP;
      oldP = pinIn;
      newP = 16'(k * 16'h1357) ^ 16'(k << 11);
      pinIn = newP;
      expectReg(8'h14, oldP, "R5 after one edge");
      expectReg(8'h14, newP, "R5 after two edges");
    end

    // R8 mask and enable gating
    doWrite(8'h04, 16'h0000); doWrite(8'h0C, 16'h0008); doWrite(8'h10, 16'h0000);
    doWrite(8'h2C, 16'h0008); doWrite(8'h28, 16'hFFFF);
    pinIn = 16'h0000;
    repeat (4) @(posedge clk);
    doWrite(8'h34, 16'hFFFF);
    pinIn = 16'h0008;
    repeat (4) @(posedge clk);
    expectReg(8'h30, 16'h0000, "R8 masked pin not pending");
    check(irqOut === 1'b0, "R8 masked irq low", {15'd0, irqOut}, 16'h0);
    doWrite(8'h28, 16'hFFF7);
    expectReg(8'h30, 16'h0008, "R8 unmask shows kept status");
    doWrite(8'h2C, 16'h0000);
    expectReg(8'h30, 16'h0000, "R8 disabled pin not pending");

    // R9 acknowledge racing a new edge on pin 0
    doWrite(8'h0C, 16'h0001); doWrite(8'h28, 16'hFFFE); doWrite(8'h2C, 16'h0001);
    pinIn = 16'h0000;
    repeat (4) @(posedge clk);
    doWrite(8'h34, 16'hFFFF);
    expectReg(8'h30, 16'h0000, "R9 cleared before race");
    pinIn = 16'h0001;
    @(posedge clk); @(posedge clk);
    doWrite(8'h34, 16'h0001);
    expectReg(8'h30, 16'h0001, "R9 new edge beats acknowledge");
    doWrite(8'h34, 16'h0001);
    expectReg(8'h30, 16'h0000, "R9 acknowledge clears");

    // R6 R7 R10 sweep: every pin, every mode
    // mode 0 level high, 1 level low, 2 rise, 3 fall, 4 both
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 5; m++) begin
        bit isLvl;
        string tag;
        isLvl = (m < 2);
        tag = isLvl ? "R6" : "R7";
        bitM = 16'(1) << p;
        idle = (m == 1 || m == 3) ? 16'hFFFF : 16'h0000;
        doWrite(8'h04, isLvl ? bitM : 16'h0);
        doWrite(8'h08, (m == 0) ? bitM : 16'h0);
        doWrite(8'h0C, (m == 2 || m == 4) ? bitM : 16'h0);
        doWrite(8'h10, (m == 3 || m == 4) ? bitM : 16'h0);
        doWrite(8'h28, ~bitM);
        doWrite(8'h2C, bitM);
        pinIn = idle;
        repeat (4) @(posedge clk);
        doWrite(8'h34, 16'hFFFF);
        expectReg(8'h30, 16'h0000, {tag, " idle"});
        pinIn = idle ^ bitM;
        repeat (4) @(posedge clk);
        expectReg(8'h30, bitM, {tag, " active"});
        check(irqOut === 1'b1, "R10 irq high", {15'd0, irqOut}, 16'h1);
        doWrite(8'h34, bitM);
        expectReg(8'h30, isLvl ? bitM : 16'h0, {tag, " after acknowledge"});
        pinIn = idle;
        repeat (4) @(posedge clk);
        expectReg(8'h30, (isLvl || m == 4) ? bitM : 16'h0, {tag, " return to idle"});
        doWrite(8'h34, 16'hFFFF);
        doRead(8'h30, v);
        check(v === 16'h0, {tag, " final clear"}, v, 16'h0);
        check(irqOut === 1'b0, "R10 irq low", {15'd0, irqOut}, 16'h0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule